// File: doc/BRIEF.md
# Real-Time Clock Register File

This block holds the 64-byte register space of a real-time clock behind a byte-level serial-bus slave. A bus front end reduces its traffic to four single-cycle strobes: a write transaction has started, a read transaction has started, a byte arrives from the master, and a byte is taken by the master. After a write start, the first byte that arrives is an address. It loads the internal register pointer and is not stored. Each later byte is written at the pointer, and each byte read is taken from the pointer. Both kinds of transfer step the pointer by one, modulo 64.

The seven lowest offsets show the time and date. The live values belong to a separate calendar counter. This block keeps a shadow copy of them. The shadow is refreshed when a read transaction starts and whenever the pointer rolls over from the top of the space, so a burst read returns one coherent time. A write that lands on a time offset is passed to the calendar counter as a one-cycle load pulse and does not touch the shadow. Offset 7 is a control byte. Some of its bits are hard-wired to zero, and it carries an oscillator-fail flag that only the oscillator monitor can set. Offsets 8 to 63 are plain byte storage.

Top module: `rtc_regfile`

## Requirements
- R1: After reset every byte of the space reads 0, the pointer is 0, and no address byte is expected, so a data byte arriving before any write start is written at offset 0.
- R2: The first byte arriving after `wr_start` sets the pointer to its low 6 bits (bits 7 and 6 are ignored) and is not stored anywhere.
- R3: Each data byte written or read advances the pointer by one, wrapping from 63 to 0.
- R4: When the pointer advances from 63 to 0, by either a read or a write, the shadow bytes 0 to 6 are reloaded from `cal_time`, where byte k is `cal_time[8k+7:8k]`.
- R5: `rd_start` loads shadow bytes 0 to 6 from `cal_time`. Reads of offsets 0 to 6 return that copy even after `cal_time` changes.
- R6: A data byte written at offset k < 7 makes `cal_wr_en` high for exactly the following cycle, with `cal_wr_sel` = k and `cal_wr_data` = the byte. The shadow byte k keeps its value.
- R7: A write at offset 7 stores the byte with bits 2, 3 and 6 cleared (AND mask 0xB3).
- R8: Control bit 5 is the oscillator-fail flag. `osc_fail_set` sets it. Writing 0 to it clears it. Writing 1 to it leaves it unchanged.
- R9: A write at offsets 8 to 63 stores the byte unchanged, and later reads return it.
- R10: `rd_data` shows the byte at the current pointer without a clock edge. The pointer advance caused by `rd_byte` takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | A write transaction has started (one cycle) |
| rd_start | input | 1 | A read transaction has started (one cycle) |
| wr_byte | input | 1 | Byte from master valid on `wr_data` |
| wr_data | input | 8 | Byte from master |
| rd_byte | input | 1 | Master takes `rd_data`; pointer advances |
| rd_data | output | 8 | Byte at the current pointer |
| osc_fail_set | input | 1 | Oscillator monitor reports a stop; sets the fail flag |
| cal_time | input | 56 | Live time bytes 0..6 from the calendar counter |
| cal_wr_en | output | 1 | Load pulse to the calendar counter |
| cal_wr_sel | output | 3 | Time byte index being loaded |
| cal_wr_data | output | 8 | Byte to load |

## Verification
The rollover refresh of the shadow is the hardest case to reach. The pointer has to stand at 63 while `cal_time` differs from the copy taken at the last read start, and this must happen without a new read start. The stimulus aims the pointer at offset 62 with an address byte, changes `cal_time`, and reads across the top of the space. In a second pass it writes across the top. After each pass it reads offset 0 without a read start, which shows whether the refresh took place. The flag rule needs `osc_fail_set` first, so that writing 1 to the flag can be told apart from a flag that never got set.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int RTC_ADDR_W    = 6;
  localparam int RTC_DATA_W    = 8;
  localparam int RTC_TIME_REGS = 7;
  localparam int RTC_CTRL_ADDR = 7;
  localparam logic [7:0] RTC_CTRL_MASK = 8'hB3;
  localparam int RTC_FAIL_BIT  = 5;
endpackage

// File: rtl/rtc_pointer.sv
`timescale 1ns/1ps
module rtc_pointer #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              wr_byte,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_byte,
  output logic [ADDR_W-1:0] ptr,
  output logic              data_wr,
  output logic              wrap
);
  logic expect_addr;
  logic advance;

  assign data_wr = wr_byte && !expect_addr;
  assign advance = data_wr || rd_byte;
  assign wrap    = advance && (ptr == {ADDR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr         <= '0;
      expect_addr <= 1'b0;
    end else if (wr_start) begin
      expect_addr <= 1'b1;
    end else if (wr_byte && expect_addr) begin
      ptr         <= addr_in;
      expect_addr <= 1'b0;
    end else if (advance) begin
      ptr <= ptr + 1'b1;
    end
  end

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !wr_start) |=> ptr == $past(ptr) + 1'b1);
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_byte && expect_addr && !wr_start) |=> ptr == $past(addr_in));
endmodule

// File: rtl/rtc_ctrl_merge.sv
`timescale 1ns/1ps
module rtc_ctrl_merge #(
  parameter int         DATA_W   = 8,
  parameter logic [7:0] MASK     = 8'hB3,
  parameter int         FAIL_BIT = 5
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              fail_set,
  output logic [DATA_W-1:0] nxt,
  output logic              upd
);
  localparam logic [DATA_W-1:0] FAIL_M = DATA_W'(1) << FAIL_BIT;
  localparam logic [DATA_W-1:0] KEEP_M = DATA_W'(MASK);
  logic [DATA_W-1:0] written;

  always_comb begin
    written = ((wdata & KEEP_M) & ~FAIL_M) | (wdata & cur & FAIL_M);
    nxt     = (wr ? written : cur) | (fail_set ? FAIL_M : '0);
    upd     = wr || fail_set;
  end
endmodule

// File: rtl/rtc_store.sv
`timescale 1ns/1ps
module rtc_store #(
  parameter int         ADDR_W    = 6,
  parameter int         DATA_W    = 8,
  parameter int         TIME_REGS = 7,
  parameter int         CTRL_ADDR = 7,
  parameter logic [7:0] CTRL_MASK = 8'hB3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        capture,
  input  logic [TIME_REGS*DATA_W-1:0] cal_time,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        ctrl_we,
  input  logic [DATA_W-1:0]           ctrl_nxt,
  input  logic [ADDR_W-1:0]           raddr,
  output logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           ctrl_q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i < TIME_REGS) begin
          if (capture) regs[i] <= cal_time[i*DATA_W +: DATA_W];
        end else if (i == CTRL_ADDR) begin
          if (ctrl_we) regs[i] <= ctrl_nxt;
        end else if (we && waddr == ADDR_W'(i)) begin
          regs[i] <= wdata;
        end
      end
    end
  end

  assign rdata  = regs[raddr];
  assign ctrl_q = regs[CTRL_ADDR];

  assert_shadow_load_R4: assert property (@(posedge clk) disable iff (rst)
    capture |=> regs[0] == $past(cal_time[DATA_W-1:0]));
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !capture |=> regs[TIME_REGS-1] == $past(regs[TIME_REGS-1]));
  assert_ctrl_mask_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (regs[CTRL_ADDR] & ~DATA_W'(CTRL_MASK)) == '0);
endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = RTC_ADDR_W,
  parameter int DATA_W    = RTC_DATA_W,
  parameter int TIME_REGS = RTC_TIME_REGS,
  parameter int CTRL_ADDR = RTC_CTRL_ADDR,
  parameter int FAIL_BIT  = RTC_FAIL_BIT,
  localparam int SEL_W    = $clog2(TIME_REGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_start,
  input  logic                        rd_start,
  input  logic                        wr_byte,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_byte,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        osc_fail_set,
  input  logic [TIME_REGS*DATA_W-1:0] cal_time,
  output logic                        cal_wr_en,
  output logic [SEL_W-1:0]            cal_wr_sel,
  output logic [DATA_W-1:0]           cal_wr_data
);
  logic [ADDR_W-1:0] ptr;
  logic              data_wr, wrap;
  logic              is_time, is_ctrl;
  logic [DATA_W-1:0] ctrl_q, ctrl_nxt;
  logic              ctrl_upd;

  rtc_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_byte(wr_byte),
    .addr_in(wr_data[ADDR_W-1:0]), .rd_byte(rd_byte),
    .ptr(ptr), .data_wr(data_wr), .wrap(wrap)
  );

  assign is_time = ptr < ADDR_W'(TIME_REGS);
  assign is_ctrl = ptr == ADDR_W'(CTRL_ADDR);

  rtc_ctrl_merge #(.DATA_W(DATA_W), .MASK(RTC_CTRL_MASK), .FAIL_BIT(FAIL_BIT)) u_ctrl (
    .cur(ctrl_q), .wdata(wr_data), .wr(data_wr && is_ctrl),
    .fail_set(osc_fail_set), .nxt(ctrl_nxt), .upd(ctrl_upd)
  );

  rtc_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_REGS(TIME_REGS),
    .CTRL_ADDR(CTRL_ADDR), .CTRL_MASK(RTC_CTRL_MASK)
  ) u_store (
    .clk(clk), .rst(rst), .capture(rd_start || wrap), .cal_time(cal_time),
    .we(data_wr && !is_time && !is_ctrl), .waddr(ptr), .wdata(wr_data),
    .ctrl_we(ctrl_upd), .ctrl_nxt(ctrl_nxt),
    .raddr(ptr), .rdata(rd_data), .ctrl_q(ctrl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_wr_en   <= 1'b0;
      cal_wr_sel  <= '0;
      cal_wr_data <= '0;
    end else begin
      cal_wr_en <= data_wr && is_time;
      if (data_wr && is_time) begin
        cal_wr_sel  <= ptr[SEL_W-1:0];
        cal_wr_data <= wr_data;
      end
    end
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_start, rd_start, wr_byte, rd_byte}));
  assert_cal_sel_R6: assert property (@(posedge clk) disable iff (rst)
    cal_wr_en |-> cal_wr_sel < SEL_W'(TIME_REGS));
  assert_cal_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cal_wr_en |=> !cal_wr_en || $past(wr_byte));
  assert_fail_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[FAIL_BIT]) |-> $past(osc_fail_set));
endmodule

// File: tb/sim_rtc_regfile.sv
`timescale 1ns/1ps
module sim_rtc_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_start = 0, rd_start = 0, wr_byte = 0, rd_byte = 0, osc_fail_set = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic [55:0] cal_time = 56'h0;
  logic        cal_wr_en;
  logic [2:0]  cal_wr_sel;
  logic [7:0]  cal_wr_data;
  int tests = 0, fails = 0;
  logic       last_en;
  logic [2:0] last_sel;
  logic [7:0] last_data;

  always #5 clk = ~clk;

  rtc_regfile u0 (
    .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
    .wr_byte(wr_byte), .wr_data(wr_data), .rd_byte(rd_byte), .rd_data(rd_data),
    .osc_fail_set(osc_fail_set), .cal_time(cal_time),
    .cal_wr_en(cal_wr_en), .cal_wr_sel(cal_wr_sel), .cal_wr_data(cal_wr_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wstart();
    @(negedge clk); wr_start = 1; @(negedge clk); wr_start = 0;
  endtask
  task automatic rstart();
    @(negedge clk); rd_start = 1; @(negedge clk); rd_start = 0;
  endtask
  task automatic wbyte(input logic [7:0] d);
    @(negedge clk); wr_byte = 1; wr_data = d;
    @(negedge clk); wr_byte = 0;
    last_en = cal_wr_en; last_sel = cal_wr_sel; last_data = cal_wr_data;
  endtask
  task automatic rbyte(output logic [7:0] d);
    @(negedge clk); rd_byte = 1; #1 d = rd_data;
    @(negedge clk); rd_byte = 0;
  endtask
  task automatic seek(input logic [7:0] a);
    wstart(); wbyte(a);
  endtask
  task automatic pulse_fail();
    @(negedge clk); osc_fail_set = 1; @(negedge clk); osc_fail_set = 0;
  endtask

  function automatic logic [7:0] tbyte(input logic [55:0] t, input int k);
    return t[k*8 +: 8];
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    int bad = 0;
    cal_time = 56'h11_22_33_44_55_66_77;
    #1 check("R10 comb read at reset", rd_data, 8'h00);
    for (int i = 0; i < 64; i++) begin
      rbyte(d);
      if (d !== 8'h00) bad++;
    end
    check("R1 all bytes zero", bad, 0);
    // pointer wrapped back to 0; a data byte with no write start goes to offset 0
    wbyte(8'h15);
    check("R1 no address expected en", last_en, 1'b1);
    check("R1 no address expected sel", last_sel, 3'd0);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    seek(8'hC9);            // bits 7:6 ignored -> offset 9
    wbyte(8'hAA); wbyte(8'h55);
    seek(8'h08);
    rbyte(d); check("R2 address byte not stored", d, 8'h00);
    rbyte(d); check("R2 low 6 bits as pointer", d, 8'hAA);
    rbyte(d); check("R3 auto increment", d, 8'h55);
    check("R9 stored unchanged", d, 8'h55);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    seek(8'd7); wbyte(8'hFF);
    seek(8'd7); rbyte(d); check("R7 mask, R8 flag stays 0", d, 8'h93);
    pulse_fail();
    seek(8'd7); rbyte(d); check("R8 set by monitor", d, 8'hB3);
    seek(8'd7); wbyte(8'hFF);
    seek(8'd7); rbyte(d); check("R8 write 1 keeps", d, 8'hB3);
    seek(8'd7); wbyte(8'hDF);
    seek(8'd7); rbyte(d); check("R8 write 0 clears", d, 8'h93);
    seek(8'd7); wbyte(8'h4C);
    seek(8'd7); rbyte(d); check("R7 forced-zero bits", d, 8'h00);
  endtask

  task automatic t_time_write();
    logic [7:0] d;
    seek(8'd2); wbyte(8'h23);
    check("R6 load pulse", last_en, 1'b1);
    check("R6 load sel", last_sel, 3'd2);
    check("R6 load data", last_data, 8'h23);
    @(negedge clk);
    check("R6 pulse one cycle", cal_wr_en, 1'b0);
    seek(8'd2); rbyte(d);
    check("R6 shadow untouched", d, tbyte(56'h11_22_33_44_55_66_77, 2));
    seek(8'd10); wbyte(8'h01);
    check("R6 no load above time regs", last_en, 1'b0);
  endtask

  task automatic t_read_start();
    logic [7:0] d;
    logic [55:0] snap = 56'h06_05_04_03_02_01_59;
    int bad = 0;
    seek(8'd0);
    cal_time = snap;
    rstart();
    cal_time = 56'hFF_FF_FF_FF_FF_FF_FF;
    for (int k = 0; k < 7; k++) begin
      rbyte(d);
      if (d !== tbyte(snap, k)) begin
        bad++;
        $display("FAIL R5 byte %0d: got %0h expected %0h", k, d, tbyte(snap, k));
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    seek(8'd62);
    cal_time = 56'hA6_A5_A4_A3_A2_A1_A0;
    rbyte(d); rbyte(d);
    rbyte(d); check("R4 wrap by read refreshes", d, 8'hA0);
    rbyte(d); check("R3 wrap continues at 1", d, 8'hA1);
    seek(8'd63); wbyte(8'h77);
    cal_time = 56'hB6_B5_B4_B3_B2_B1_B0;
    rbyte(d); check("R4 wrap by write captured old", d, 8'hA0);
    cal_time = 56'hC6_C5_C4_C3_C2_C1_C0;
    seek(8'd63); wbyte(8'h78);
    rbyte(d); check("R4 wrap by write refreshes", d, 8'hC0);
    seek(8'd63); rbyte(d); check("R9 top byte stored", d, 8'h78);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_pointer();
    t_ctrl();
    t_time_write();
    t_read_start();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule